// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave with Deferred Mode Update

This block lets a host configure a video picture processor over a two-wire I2C bus. It acts only as a receiver. It samples SCL and SDA with the system clock and finds start and stop conditions. It checks for a fixed 7-bit device address with the write direction bit, then takes one subaddress byte. After that it takes any number of data bytes. Each data byte goes into the next register of a bank of four 8-bit shadow registers, because the pointer advances after every byte.

The shadow values do not reach the active operating-mode outputs at once. In single-picture mode the whole bank is copied to the outputs right after each data byte is written. In multi-picture mode the copy waits for the vertical blanking interval: it happens on the first system clock on which the vertical sync input and the data-request input are both high. It happens at most once per sync high phase.

The receive sequencer has seven states:
- `ST_IDLE`: waits for a start condition.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_SUB`: shifts in the subaddress.
- `ST_SUB_ACK`: acknowledges the subaddress.
- `ST_DATA`: shifts in a data byte.
- `ST_DATA_ACK`: acknowledges the data byte.

Transitions:
- A start condition goes from any state to `ST_ADDR`. A stop condition goes from any state to `ST_IDLE`.
- On the SCL falling edge that ends the eighth bit, a full byte moves:
  - `ST_ADDR` to `ST_ADDR_ACK` if the address matches, otherwise to `ST_IDLE`;
  - `ST_SUB` to `ST_SUB_ACK`;
  - `ST_DATA` to `ST_DATA_ACK` if the pointer is in range, otherwise to `ST_IDLE`.
- On the next SCL falling edge, each acknowledge state moves on: `ST_ADDR_ACK` to `ST_SUB`, and both `ST_SUB_ACK` and `ST_DATA_ACK` to `ST_DATA`.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: The block acknowledges only the address byte 0x2A, which is the 7-bit address 0010101 followed by the write bit 0. Any other address, and the same address with the read bit 1, is not acknowledged and changes no register.
- R2: A start condition (SDA falls while SCL is high) restarts address matching from any state, including in the middle of a transfer. A stop condition (SDA rises while SCL is high) ends the transfer, so later bytes sent without a new start are neither acknowledged nor stored.
- R3: For an accepted byte, `sda_oe_o` is high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth clock. It is low at all other times.
- R4: The subaddress byte selects register 0 to 3. Each data byte that is acknowledged writes the selected register, then advances the pointer by one.
- R5: If the pointer is above 3, whether it was set that way by the subaddress or reached by auto-increment, the data byte is not acknowledged and no register changes.
- R6: Bits 7..5 of register 2 (`mode_o[23:21]`) are always 0, whatever value is written.
- R7: Bit 3 of register 0 (`mode_o[3]`) is always 0, whatever value is written.
- R8: After reset, `mode_o` equals `RESET_VAL` (default 0x00100820, register 0 in the low byte) and `sda_oe_o` is low.
- R9: With `multi_mode_i` low, `mode_o` reflects each written data byte before the acknowledge clock of that byte ends.
- R10: With `multi_mode_i` high, `mode_o` holds its value while `vsync_i` is low. The shadow bank is copied to `mode_o` one clock after the first clock on which `vsync_i` and `dreq_i` are both high, and only once per `vsync_i` high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| scl_i | input | 1 | I2C clock line (asynchronous) |
| sda_i | input | 1 | I2C data line as seen on the bus (asynchronous) |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low for acknowledge |
| vsync_i | input | 1 | Vertical sync; high marks the blanking interval |
| dreq_i | input | 1 | Mode-change request from the sync controller |
| multi_mode_i | input | 1 | High selects deferred (multi-picture) update |
| mode_o | output | NREG*8 | Active registers; byte i is register i |

## Verification
A wrong sequencer state shows at the ports within one byte time. Either the acknowledge pull-down is missing, or it appears on the wrong ninth clock, or a register changes that should not. A wrong pointer shows as a write to the neighbouring register, or as an acknowledge that should have been a refusal once the pointer passes 3. These errors are visible on `mode_o` or on the ninth-clock SDA level of that same transfer. A broken deferred-copy flag shows within one sync phase, as an output that changes outside blanking, changes twice in one phase, or never takes the new setting.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK
    } rx_state_t;

    // Writable bits of each register; fixed-zero fields are cleared.
    function automatic logic [7:0] keep_mask(input int idx);
        case (idx)
            0:       return 8'hF7;
            2:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ctlreg_i2c_edge.sv
module ctlreg_i2c_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_ff, sda_ff;
    logic         scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[MSB-1:0], scl_i};
            sda_ff <= {sda_ff[MSB-1:0], sda_i};
            scl_q  <= scl_ff[MSB];
            sda_q  <= sda_ff[MSB];
        end
    end

    assign scl_s     = scl_ff[MSB];
    assign sda_s     = sda_ff[MSB];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ctlreg_i2c_rx.sv
module ctlreg_i2c_rx
    import ctlreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0010101,
    parameter int         NREG     = 4,
    localparam int        AW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data
);
    rx_state_t  state, state_n;
    logic [7:0] shreg;
    logic [3:0] bit_cnt;
    logic [7:0] ptr;
    logic       byte_full, addr_hit, ptr_ok, shifting, is_ack_n;

    assign byte_full = (bit_cnt == 4'd8);
    assign addr_hit  = (shreg == {DEV_ADDR, 1'b0});
    assign ptr_ok    = (ptr < 8'(NREG));
    assign shifting  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign is_ack_n  = (state_n == ST_ADDR_ACK) || (state_n == ST_SUB_ACK) ||
                       (state_n == ST_DATA_ACK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full)
                                 state_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_SUB:      if (scl_fall && byte_full) state_n = ST_SUB_ACK;
                ST_DATA:     if (scl_fall && byte_full)
                                 state_n = ptr_ok ? ST_DATA_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_n = ST_SUB;
                ST_SUB_ACK,
                ST_DATA_ACK: if (scl_fall) state_n = ST_DATA;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (shifting) begin
                if (scl_rise && !byte_full) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_fall && byte_full) begin
                    bit_cnt <= '0;
                    sda_oe  <= is_ack_n;
                    if (state == ST_SUB) ptr <= shreg;
                    if (state == ST_DATA && ptr_ok) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr[AW-1:0];
                        wr_data <= shreg;
                        ptr     <= ptr + 8'd1;
                    end
                end
            end else if (state != ST_IDLE && scl_fall) begin
                sda_oe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter int              NREG      = 4,
    parameter logic [NREG*8-1:0] RESET_VAL = 32'h0010_0820,
    localparam int             AW        = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              multi_mode,
    input  logic              vsync,
    input  logic              dreq,
    output logic              copy_multi,
    output logic [NREG*8-1:0] mode_q
);
    logic [7:0] shadow [NREG];
    logic [7:0] active [NREG];
    logic       single_pend, phase_done, copy;

    assign copy_multi = multi_mode & vsync & dreq & ~phase_done;
    assign copy       = copy_multi | (~multi_mode & single_pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_pend <= 1'b0;
            phase_done  <= 1'b0;
        end else begin
            single_pend <= wr_en & ~multi_mode;
            if (!vsync)          phase_done <= 1'b0;
            else if (copy_multi) phase_done <= 1'b1;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[i] <= RESET_VAL[i*8 +: 8] & keep_mask(i);
            else if (wr_en && wr_idx == AW'(i))
                shadow[i] <= wr_data & keep_mask(i);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    active[i] <= RESET_VAL[i*8 +: 8] & keep_mask(i);
            else if (copy) active[i] <= shadow[i];
        end
        assign mode_q[i*8 +: 8] = active[i];
    end

endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave #(
    parameter logic [6:0]        DEV_ADDR  = 7'b0010101,
    parameter int                NREG      = 4,
    parameter logic [NREG*8-1:0] RESET_VAL = 32'h0010_0820,
    parameter int                SYNC_STAGES = 2,
    localparam int               AW        = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              vsync_i,
    input  logic              dreq_i,
    input  logic              multi_mode_i,
    output logic [NREG*8-1:0] mode_o
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en, copy_multi;
    logic [AW-1:0] wr_idx;
    logic [7:0]    wr_data;

    ctlreg_i2c_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk, .rst_n, .scl_i, .sda_i,
        .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
    );

    ctlreg_i2c_rx #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_rx (
        .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
        .sda_oe(sda_oe_o), .wr_en, .wr_idx, .wr_data
    );

    ctlreg_bank #(.NREG(NREG), .RESET_VAL(RESET_VAL)) u_bank (
        .clk, .rst_n, .wr_en, .wr_idx, .wr_data,
        .multi_mode(multi_mode_i), .vsync(vsync_i), .dreq(dreq_i),
        .copy_multi, .mode_q(mode_o)
    );

endmodule

// File: rtl/ctlreg_i2c_slave_chk.sv
module ctlreg_i2c_slave_chk #(
    parameter int NREG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe_o,
    input logic              multi_mode_i,
    input logic              vsync_i,
    input logic              copy_multi,
    input logic [NREG*8-1:0] mode_o
);
    // R3: the acknowledge drive only changes after an SCL fall or a bus condition
    p_oe_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));

    // R6: upper bits of register 2 stay zero
    p_reg2_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[23:21] == 3'b000);

    // R7: fixed field of register 0 stays zero
    p_reg0_bit3_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[3] == 1'b0);

    // R10: outside blanking the active mode holds in deferred mode
    p_hold_outside_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode_i && !vsync_i) |=> $stable(mode_o));

    // R10: at most one deferred copy per sync high phase
    p_single_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        copy_multi |=> !copy_multi);

endmodule

bind ctlreg_i2c_slave ctlreg_i2c_slave_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe_o(sda_oe_o), .multi_mode_i(multi_mode_i),
    .vsync_i(vsync_i), .copy_multi(copy_multi), .mode_o(mode_o)
);

// File: tb/ctlreg_i2c_slave_tb.sv
module ctlreg_i2c_slave_tb;
    localparam int          Q      = 10;
    localparam logic [31:0] DEFS   = 32'h0010_0820;
    localparam logic [7:0]  WADDR  = 8'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1, sda_drv = 1'b1;
    logic        vsync = 1'b0, dreq = 1'b0, multi = 1'b0;
    logic        sda_oe;
    logic [31:0] mode;
    wire         sda_line = sda_drv & ~sda_oe;

    int checks = 0, errors = 0;
    logic [31:0] exp_mode;
    logic        ack, oe_pre, oe_post;

    always #2 clk = ~clk;

    ctlreg_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .vsync_i(vsync), .dreq_i(dreq),
        .multi_mode_i(multi), .mode_o(mode)
    );

    function automatic logic [7:0] fix(input int idx, input logic [7:0] v);
        if (idx == 0) return v & 8'hF7;
        if (idx == 2) return v & 8'h1F;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        wq(); sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq(); scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq();
        sda_drv = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_drv = b[i]; wq(); scl_drv = 1'b1; wq(); scl_drv = 1'b0;
        end
        wq(); sda_drv = 1'b1; wq();
        oe_pre = sda_oe;
        scl_drv = 1'b1; wq();
        ack = ~sda_line;
        scl_drv = 1'b0; wq();
        oe_post = sda_oe;
    endtask

    task automatic t_reset();
        chk(mode === DEFS, "R8 reset value", mode, DEFS);
        chk(sda_oe === 1'b0, "R8 sda_oe idle", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_address();
        bus_start(); send_byte(8'h2C);
        chk(ack == 1'b0, "R1 foreign address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h00); send_byte(8'h99); bus_stop();
        chk(mode === exp_mode, "R1 foreign address no write", mode, exp_mode);
        bus_start(); send_byte(8'h2B);
        chk(ack == 1'b0, "R1 read bit nack", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start(); send_byte(WADDR);
        chk(ack == 1'b1, "R1 own address ack", {31'd0, ack}, 32'd1);
        chk(oe_pre == 1'b1, "R3 drive before ninth clock", {31'd0, oe_pre}, 32'd1);
        chk(oe_post == 1'b0, "R3 release after ninth clock", {31'd0, oe_post}, 32'd0);
        send_byte(8'h00); send_byte(8'h11);
        exp_mode[7:0] = fix(0, 8'h11);
        chk(mode === exp_mode, "R9 single-mode write reg0", mode, exp_mode);
        bus_stop();
    endtask

    task automatic t_autoinc();
        bus_start(); send_byte(WADDR); send_byte(8'h01);
        send_byte(8'hA1); exp_mode[15:8] = fix(1, 8'hA1);
        send_byte(8'hB2); exp_mode[23:16] = fix(2, 8'hB2);
        send_byte(8'hC3); exp_mode[31:24] = fix(3, 8'hC3);
        chk(ack == 1'b1, "R4 last auto-increment ack", {31'd0, ack}, 32'd1);
        bus_stop();
        chk(mode === exp_mode, "R4 auto-increment regs 1..3", mode, exp_mode);
    endtask

    task automatic t_range();
        bus_start(); send_byte(WADDR); send_byte(8'h03);
        send_byte(8'h5A); exp_mode[31:24] = 8'h5A;
        chk(ack == 1'b1, "R4 reg3 ack", {31'd0, ack}, 32'd1);
        send_byte(8'h6B);
        chk(ack == 1'b0, "R5 past reg3 nack", {31'd0, ack}, 32'd0);
        bus_stop();
        chk(mode === exp_mode, "R5 past reg3 no change", mode, exp_mode);
        bus_start(); send_byte(WADDR); send_byte(8'h04);
        chk(ack == 1'b1, "R5 subaddress ack", {31'd0, ack}, 32'd1);
        send_byte(8'h77);
        chk(ack == 1'b0, "R5 subaddress 4 nack", {31'd0, ack}, 32'd0);
        bus_stop();
        chk(mode === exp_mode, "R5 subaddress 4 no change", mode, exp_mode);
    endtask

    task automatic t_masks();
        bus_start(); send_byte(WADDR); send_byte(8'h00);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'hFF); bus_stop();
        chk(mode[7:0] === 8'hF7, "R7 reg0 bit3 zero", {24'd0, mode[7:0]}, 32'hF7);
        chk(mode[15:8] === 8'h00, "R4 reg1 cleared", {24'd0, mode[15:8]}, 32'h00);
        chk(mode[23:16] === 8'h1F, "R6 reg2 top bits zero", {24'd0, mode[23:16]}, 32'h1F);
        exp_mode[23:0] = 24'h1F00F7;
    endtask

    task automatic t_restart();
        bus_start(); send_byte(WADDR); send_byte(8'h00);
        bus_start(); send_byte(WADDR);
        chk(ack == 1'b1, "R2 repeated start address ack", {31'd0, ack}, 32'd1);
        send_byte(8'h02); send_byte(8'h0C); bus_stop();
        exp_mode[23:16] = 8'h0C;
        chk(mode === exp_mode, "R2 repeated start write", mode, exp_mode);
        bus_start(); send_byte(WADDR); send_byte(8'h01); bus_stop();
        send_byte(8'h99);
        chk(ack == 1'b0, "R2 byte after stop nack", {31'd0, ack}, 32'd0);
        chk(mode === exp_mode, "R2 byte after stop no write", mode, exp_mode);
    endtask

    task automatic t_multi();
        multi = 1'b1; vsync = 1'b0; dreq = 1'b0;
        bus_start(); send_byte(WADDR); send_byte(8'h01); send_byte(8'h3C); bus_stop();
        chk(mode === exp_mode, "R10 held outside blanking", mode, exp_mode);
        vsync = 1'b1; repeat (20) @(negedge clk);
        chk(mode === exp_mode, "R10 held without request", mode, exp_mode);
        dreq = 1'b1; @(negedge clk); @(negedge clk);
        exp_mode[15:8] = 8'h3C;
        chk(mode === exp_mode, "R10 copied in blanking", mode, exp_mode);
        bus_start(); send_byte(WADDR); send_byte(8'h01); send_byte(8'h4D); bus_stop();
        chk(mode === exp_mode, "R10 one copy per phase", mode, exp_mode);
        vsync = 1'b0; repeat (5) @(negedge clk);
        vsync = 1'b1; @(negedge clk); @(negedge clk);
        exp_mode[15:8] = 8'h4D;
        chk(mode === exp_mode, "R10 next phase copy", mode, exp_mode);
        vsync = 1'b0; dreq = 1'b0; multi = 1'b0;
    endtask

    initial begin
        exp_mode = DEFS;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_address();
        t_autoinc();
        t_range();
        t_masks();
        t_restart();
        t_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule